// File: doc/BRIEF.md
# Secure Enclave Launch Policy Checker

This block makes the final admission decision before an isolated execution region may be marked initialized. The fields it judges arrive already extracted: the signed descriptor, the launch token and the region's control record. Results computed elsewhere arrive alongside them: the signature-verify outcome, the finalized measurement digest, the digest of the signer's public key, the hash of the authorized launcher key and the token MAC comparison. No hashing, RSA, CMAC or key derivation happens inside.

A one-cycle `start_i` request is accepted while the block is idle. The block then walks its policy checks one stage per clock in a fixed order and stops at the first check that fails. The signature stage is a window several cycles long, and a pending unmasked event aborts it. When the launch token is marked not valid, every token check is skipped. On completion the block raises `done_o` for exactly one cycle. It presents a zero flag and a 4-bit error code, and these are held until the next accepted request. On success it also pulses a commit strobe that carries the signer identity, the measurement, the product ID and the version to be written into the control record. All data inputs must stay stable from the request until `done_o`.

Top module: `lp_launch_chk`

## Requirements
- R1: A request is a fault when the descriptor or record address has any of bits [11:0] set, when the token address has any of bits [8:0] set, when `rec_init_i` is 1 or when `rec_lock_i` is 1. A fault gives `fault_o`=1 and `done_o`=1 on the clock after the request, with `zf_o`=0, `err_o`=0 and no commit.
- R2: The descriptor structure is accepted only when all of the following hold: header 1 is 06000000E10000000000010000000000h, header 2 is 01010000600000006000000001000000h, the vendor is 0 or 00008086h, the exponent is 3, and the reserved field is zero. Otherwise the result is error code 1 (bad structure), one clock after the request.
- R3: A `sig_event_i` seen in any cycle of the signature window aborts with code 7 (event), two clocks after the request, and it takes precedence over a verify failure.
- R4: When `sig_ok_i`=0 at the end of a window of SIG_WIN cycles (default 4), the result is code 4 (bad signature) at latency 1+SIG_WIN.
- R5: A non-zero family ID while record attribute bit 7 (the key-separation enable) is 0 gives code 1 at latency 2+SIG_WIN.
- R6: When the descriptor's enclave hash differs from `meas_final_i`, the result is code 3 (bad measurement) at latency 3+SIG_WIN.
- R7: When a record attribute bit under the controlled mask 0x20 is set and `signer_dig_i` differs from `launcher_hash_i`, the result is code 2 (bad attribute) at latency 4+SIG_WIN.
- R8: When (record attributes AND mask) differs from (descriptor attributes AND mask), the result is code 2 at latency 5+SIG_WIN. The same masked comparison on the misc-select fields gives code 2 at latency 6+SIG_WIN.
- R9: When `tok_valid_i`=0, a signer digest that differs from the launcher hash gives code 5 (bad token) at latency 7+SIG_WIN. Otherwise the request succeeds at that latency, and no token field is looked at.
- R10: With a valid token, the checks run in this order, each one cycle after the previous and starting at latency 7+SIG_WIN. First, a debug token (`tok_dbg_i`=1) with record attribute bit 1 = 0 gives code 5. Then a non-zero token reserved field gives code 5. Then a token SVN above `cur_svn_i` gives code 6. Then a MAC mismatch gives code 5. Then a token measurement or signer that differs from `meas_final_i` or `signer_dig_i` gives code 3. Last, token attributes that differ from the record attributes give code 8. Success comes at latency 12+SIG_WIN.
- R11: On success `zf_o`=0 and `err_o`=0, and `cm_we_o` pulses together with `done_o`. The commit outputs carry the signer digest, the finalized measurement, the descriptor product ID and the descriptor version. On any failure `zf_o`=1 with the error code, and there is no commit.
- R12: `done_o` is high for one cycle only and `busy_o` is high while checks run. `zf_o`, `err_o` and `fault_o` hold their values while idle until the next request, and reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request pulse, taken while idle |
| dsc_addr_i | input | ADDR_W | Descriptor address (4 KiB alignment) |
| rec_addr_i | input | ADDR_W | Control record address (4 KiB alignment) |
| tok_addr_i | input | ADDR_W | Token address (512 B alignment) |
| rec_init_i | input | 1 | Record already initialized |
| rec_lock_i | input | 1 | Another operation is modifying the record |
| dsc_hdr1_i | input | 128 | Descriptor first header |
| dsc_vendor_i | input | 32 | Descriptor vendor |
| dsc_hdr2_i | input | 128 | Descriptor second header |
| dsc_exp_i | input | 32 | Descriptor key exponent |
| dsc_rsvd_i | input | RSV_W | Descriptor reserved bits, OR-folded |
| sig_event_i | input | 1 | Unmasked event pending |
| sig_ok_i | input | 1 | Signature verify result |
| dsc_family_i | input | FAM_W | Descriptor family ID |
| rec_attr_i | input | ATTR_W | Record attributes |
| dsc_attr_i | input | ATTR_W | Descriptor attributes |
| dsc_amask_i | input | ATTR_W | Descriptor attribute mask |
| rec_misc_i | input | MISC_W | Record misc-select |
| dsc_misc_i | input | MISC_W | Descriptor misc-select |
| dsc_mmask_i | input | MISC_W | Descriptor misc mask |
| meas_final_i | input | DIG_W | Finalized measurement |
| dsc_ehash_i | input | DIG_W | Descriptor enclave hash |
| signer_dig_i | input | DIG_W | Digest of the signer key |
| launcher_hash_i | input | DIG_W | Authorized launcher key hash |
| tok_valid_i | input | 1 | Token valid bit |
| tok_dbg_i | input | 1 | Token issued by a debug launcher |
| tok_rsvd_i | input | RSV_W | Token reserved bits |
| tok_svn_i | input | SVN_W | Token processor SVN |
| cur_svn_i | input | SVN_W | Current processor SVN |
| tok_mac_ok_i | input | 1 | Token MAC matches |
| tok_meas_i | input | DIG_W | Token measurement |
| tok_signer_i | input | DIG_W | Token signer digest |
| tok_attr_i | input | ATTR_W | Token attributes |
| dsc_prod_i | input | ID_W | Descriptor product ID |
| dsc_ver_i | input | ID_W | Descriptor version |
| busy_o | output | 1 | Checks in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | General-protection fault result |
| zf_o | output | 1 | Zero flag: 1 on policy failure |
| err_o | output | 4 | Error code |
| cm_we_o | output | 1 | Commit strobe to the record |
| cm_signer_o | output | DIG_W | Committed signer identity |
| cm_meas_o | output | DIG_W | Committed measurement |
| cm_prod_o | output | ID_W | Committed product ID |
| cm_ver_o | output | ID_W | Committed version |

## Verification
Every check stage is tried with a vector that is otherwise valid and breaks that one stage, and the reported code and completion latency show which stage raised the failure. Random vectors that break two stages at once show that the earlier one in the order wins, for example an event together with a bad signature, or a token SVN fault together with a MAC fault. Fully valid vectors on both the token-valid and token-skipped paths tell the 7+SIG_WIN and 12+SIG_WIN success latencies apart and check the commit payload. The fault conditions are also covered: each alignment, the initialized record and the locked record.

// File: rtl/lp_pkg.sv
`timescale 1ns/1ps
package lp_pkg;

    typedef enum logic [3:0] {
        LE_NONE   = 4'd0,
        LE_STRUCT = 4'd1,
        LE_ATTR   = 4'd2,
        LE_MEAS   = 4'd3,
        LE_SIG    = 4'd4,
        LE_TOKEN  = 4'd5,
        LE_CPUSVN = 4'd6,
        LE_EVENT  = 4'd7,
        LE_TATTR  = 4'd8
    } lp_err_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_SIGWIN, ST_FAM, ST_MEAS, ST_CTRL, ST_AMASK,
        ST_MISC, ST_TOKSEL, ST_RSV, ST_SVN, ST_MAC, ST_TID, ST_TATTR
    } lp_state_e;

    localparam logic [127:0] HDR1_VAL   = 128'h06000000E10000000000010000000000;
    localparam logic [127:0] HDR2_VAL   = 128'h01010000600000006000000001000000;
    localparam logic [31:0]  VENDOR_ALT = 32'h00008086;
    localparam logic [31:0]  EXP_VAL    = 32'd3;

endpackage

// File: rtl/lp_align.sv
`timescale 1ns/1ps
module lp_align #(
    parameter int ADDR_W    = 48,
    parameter int ALIGN_LOG = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << ALIGN_LOG) - ADDR_W'(1);

    assign ok_o = ((addr_i & LOW_MASK) == '0);
endmodule

// File: rtl/lp_desc_check.sv
`timescale 1ns/1ps
module lp_desc_check #(
    parameter int RSV_W = 32
) (
    input  logic [127:0]     hdr1_i,
    input  logic [31:0]      vendor_i,
    input  logic [127:0]     hdr2_i,
    input  logic [31:0]      exp_i,
    input  logic [RSV_W-1:0] rsvd_i,
    output logic             ok_o
);
    import lp_pkg::*;

    logic vendor_ok;

    assign vendor_ok = (vendor_i == '0) || (vendor_i == VENDOR_ALT);
    assign ok_o      = (hdr1_i == HDR1_VAL) && (hdr2_i == HDR2_VAL) &&
                       vendor_ok && (exp_i == EXP_VAL) && (rsvd_i == '0);
endmodule

// File: rtl/lp_masked_eq.sv
`timescale 1ns/1ps
module lp_masked_eq #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] mask_i,
    output logic         eq_o
);
    assign eq_o = ((a_i & mask_i) == (b_i & mask_i));
endmodule

// File: rtl/lp_launch_chk.sv
`timescale 1ns/1ps
module lp_launch_chk #(
    parameter int ADDR_W   = 48,
    parameter int RSV_W    = 32,
    parameter int FAM_W    = 128,
    parameter int ATTR_W   = 64,
    parameter int MISC_W   = 32,
    parameter int DIG_W    = 256,
    parameter int SVN_W    = 128,
    parameter int ID_W     = 16,
    parameter int SIG_WIN  = 4,
    parameter int KSEP_BIT = 7,
    parameter int DBG_BIT  = 1,
    parameter logic [ATTR_W-1:0] CTRL_MASK = 64'h20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] dsc_addr_i,
    input  logic [ADDR_W-1:0] rec_addr_i,
    input  logic [ADDR_W-1:0] tok_addr_i,
    input  logic              rec_init_i,
    input  logic              rec_lock_i,
    input  logic [127:0]      dsc_hdr1_i,
    input  logic [31:0]       dsc_vendor_i,
    input  logic [127:0]      dsc_hdr2_i,
    input  logic [31:0]       dsc_exp_i,
    input  logic [RSV_W-1:0]  dsc_rsvd_i,
    input  logic              sig_event_i,
    input  logic              sig_ok_i,
    input  logic [FAM_W-1:0]  dsc_family_i,
    input  logic [ATTR_W-1:0] rec_attr_i,
    input  logic [ATTR_W-1:0] dsc_attr_i,
    input  logic [ATTR_W-1:0] dsc_amask_i,
    input  logic [MISC_W-1:0] rec_misc_i,
    input  logic [MISC_W-1:0] dsc_misc_i,
    input  logic [MISC_W-1:0] dsc_mmask_i,
    input  logic [DIG_W-1:0]  meas_final_i,
    input  logic [DIG_W-1:0]  dsc_ehash_i,
    input  logic [DIG_W-1:0]  signer_dig_i,
    input  logic [DIG_W-1:0]  launcher_hash_i,
    input  logic              tok_valid_i,
    input  logic              tok_dbg_i,
    input  logic [RSV_W-1:0]  tok_rsvd_i,
    input  logic [SVN_W-1:0]  tok_svn_i,
    input  logic [SVN_W-1:0]  cur_svn_i,
    input  logic              tok_mac_ok_i,
    input  logic [DIG_W-1:0]  tok_meas_i,
    input  logic [DIG_W-1:0]  tok_signer_i,
    input  logic [ATTR_W-1:0] tok_attr_i,
    input  logic [ID_W-1:0]   dsc_prod_i,
    input  logic [ID_W-1:0]   dsc_ver_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              zf_o,
    output logic [3:0]        err_o,
    output logic              cm_we_o,
    output logic [DIG_W-1:0]  cm_signer_o,
    output logic [DIG_W-1:0]  cm_meas_o,
    output logic [ID_W-1:0]   cm_prod_o,
    output logic [ID_W-1:0]   cm_ver_o
);
    import lp_pkg::*;

    localparam int WIN_W = (SIG_WIN > 1) ? $clog2(SIG_WIN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SIG_WIN - 1);

    typedef struct packed {
        lp_state_e        st;
        logic [WIN_W-1:0] win;
        logic             done;
        logic             fault;
        logic             zf;
        lp_err_e          err;
        logic             cm_we;
        logic [DIG_W-1:0] cm_signer;
        logic [DIG_W-1:0] cm_meas;
        logic [ID_W-1:0]  cm_prod;
        logic [ID_W-1:0]  cm_ver;
    } lp_regs_t;

    lp_regs_t r_q, r_d;

    // Stage predicates from helper blocks
    logic dsc_al_ok, rec_al_ok, tok_al_ok, desc_ok, attr_eq, misc_eq;

    lp_align #(.ADDR_W(ADDR_W), .ALIGN_LOG(12)) u_al_dsc (.addr_i(dsc_addr_i), .ok_o(dsc_al_ok));
    lp_align #(.ADDR_W(ADDR_W), .ALIGN_LOG(12)) u_al_rec (.addr_i(rec_addr_i), .ok_o(rec_al_ok));
    lp_align #(.ADDR_W(ADDR_W), .ALIGN_LOG(9))  u_al_tok (.addr_i(tok_addr_i), .ok_o(tok_al_ok));

    lp_desc_check #(.RSV_W(RSV_W)) u_desc (
        .hdr1_i  (dsc_hdr1_i),
        .vendor_i(dsc_vendor_i),
        .hdr2_i  (dsc_hdr2_i),
        .exp_i   (dsc_exp_i),
        .rsvd_i  (dsc_rsvd_i),
        .ok_o    (desc_ok)
    );

    lp_masked_eq #(.W(ATTR_W)) u_attr_eq (
        .a_i(rec_attr_i), .b_i(dsc_attr_i), .mask_i(dsc_amask_i), .eq_o(attr_eq)
    );
    lp_masked_eq #(.W(MISC_W)) u_misc_eq (
        .a_i(rec_misc_i), .b_i(dsc_misc_i), .mask_i(dsc_mmask_i), .eq_o(misc_eq)
    );

    logic    signer_auth, fam_bad, ctrl_bad, dbg_bad, id_bad;
    logic    finish;
    lp_err_e fin_err;

    assign signer_auth = (signer_dig_i == launcher_hash_i);
    assign fam_bad     = (dsc_family_i != '0) && !rec_attr_i[KSEP_BIT];
    assign ctrl_bad    = ((rec_attr_i & CTRL_MASK) != '0) && !signer_auth;
    assign dbg_bad     = tok_dbg_i && !rec_attr_i[DBG_BIT];
    assign id_bad      = (tok_meas_i != meas_final_i) || (tok_signer_i != signer_dig_i);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.cm_we = 1'b0;
        finish    = 1'b0;
        fin_err   = LE_NONE;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.zf    = 1'b0;
                    r_d.err   = LE_NONE;
                    r_d.fault = 1'b0;
                    if (!(dsc_al_ok && rec_al_ok && tok_al_ok) || rec_init_i || rec_lock_i) begin
                        r_d.fault = 1'b1;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.st = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                if (!desc_ok) begin finish = 1'b1; fin_err = LE_STRUCT; end
                else begin r_d.st = ST_SIGWIN; r_d.win = '0; end
            end
            ST_SIGWIN: begin
                if (sig_event_i) begin
                    finish = 1'b1; fin_err = LE_EVENT;
                end else if (r_q.win == WIN_LAST) begin
                    if (!sig_ok_i) begin finish = 1'b1; fin_err = LE_SIG; end
                    else r_d.st = ST_FAM;
                end else begin
                    r_d.win = r_q.win + WIN_W'(1);
                end
            end
            ST_FAM: begin
                if (fam_bad) begin finish = 1'b1; fin_err = LE_STRUCT; end
                else r_d.st = ST_MEAS;
            end
            ST_MEAS: begin
                if (dsc_ehash_i != meas_final_i) begin finish = 1'b1; fin_err = LE_MEAS; end
                else r_d.st = ST_CTRL;
            end
            ST_CTRL: begin
                if (ctrl_bad) begin finish = 1'b1; fin_err = LE_ATTR; end
                else r_d.st = ST_AMASK;
            end
            ST_AMASK: begin
                if (!attr_eq) begin finish = 1'b1; fin_err = LE_ATTR; end
                else r_d.st = ST_MISC;
            end
            ST_MISC: begin
                if (!misc_eq) begin finish = 1'b1; fin_err = LE_ATTR; end
                else r_d.st = ST_TOKSEL;
            end
            ST_TOKSEL: begin
                if (!tok_valid_i) begin
                    finish  = 1'b1;
                    fin_err = signer_auth ? LE_NONE : LE_TOKEN;
                end else if (dbg_bad) begin
                    finish = 1'b1; fin_err = LE_TOKEN;
                end else begin
                    r_d.st = ST_RSV;
                end
            end
            ST_RSV: begin
                if (tok_rsvd_i != '0) begin finish = 1'b1; fin_err = LE_TOKEN; end
                else r_d.st = ST_SVN;
            end
            ST_SVN: begin
                if (tok_svn_i > cur_svn_i) begin finish = 1'b1; fin_err = LE_CPUSVN; end
                else r_d.st = ST_MAC;
            end
            ST_MAC: begin
                if (!tok_mac_ok_i) begin finish = 1'b1; fin_err = LE_TOKEN; end
                else r_d.st = ST_TID;
            end
            ST_TID: begin
                if (id_bad) begin finish = 1'b1; fin_err = LE_MEAS; end
                else r_d.st = ST_TATTR;
            end
            ST_TATTR: begin
                finish  = 1'b1;
                fin_err = (tok_attr_i != rec_attr_i) ? LE_TATTR : LE_NONE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (finish) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
            r_d.err  = fin_err;
            r_d.zf   = (fin_err != LE_NONE);
            if (fin_err == LE_NONE) begin
                r_d.cm_we     = 1'b1;
                r_d.cm_signer = signer_dig_i;
                r_d.cm_meas   = meas_final_i;
                r_d.cm_prod   = dsc_prod_i;
                r_d.cm_ver    = dsc_ver_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, err: LE_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign fault_o     = r_q.fault;
    assign zf_o        = r_q.zf;
    assign err_o       = r_q.err;
    assign cm_we_o     = r_q.cm_we;
    assign cm_signer_o = r_q.cm_signer;
    assign cm_meas_o   = r_q.cm_meas;
    assign cm_prod_o   = r_q.cm_prod;
    assign cm_ver_o    = r_q.cm_ver;

endmodule

// File: rtl/lp_launch_sva.sv
`timescale 1ns/1ps
module lp_launch_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       rec_init,
    input logic       rec_lock,
    input logic       busy,
    input logic       done,
    input logic       fault,
    input logic       zf,
    input logic [3:0] err,
    input logic       cm_we
);
    // R12: completion strobe lasts a single cycle
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: commit only on a clean, non-faulting completion
    a_r11_commit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> (done && !zf && (err == 4'd0) && !fault));

    // R1: a fault never commits and never flags a policy error
    a_r1_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!cm_we && !zf));

    // R1: request on an initialized or locked record faults on the next clock
    a_r1_locked_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (rec_init || rec_lock)) |=> (done && fault));

    // R11: zero flag agrees with the error code at completion
    a_r11_zf_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (zf == (err != 4'd0)));

    // R12: results hold while idle without a request
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(err) && $stable(zf) && $stable(fault)));
endmodule

bind lp_launch_chk lp_launch_sva u_lp_launch_sva (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .start   (start_i),
    .rec_init(rec_init_i),
    .rec_lock(rec_lock_i),
    .busy    (busy_o),
    .done    (done_o),
    .fault   (fault_o),
    .zf      (zf_o),
    .err     (err_o),
    .cm_we   (cm_we_o)
);

// File: tb/test_lp_launch_chk.sv
`timescale 1ns/1ps
module test_lp_launch_chk;
    localparam int W = 4;
    localparam logic [127:0] H1 = 128'h06000000E10000000000010000000000;
    localparam logic [127:0] H2 = 128'h01010000600000006000000001000000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [47:0] dsc_addr, rec_addr, tok_addr;
    logic rec_init, rec_lock, evt, sig_ok, tok_valid, tok_dbg, mac_ok;
    logic [127:0] hdr1, hdr2, family, tok_svn, cur_svn;
    logic [31:0] vendor, expo, drsvd, trsvd, rmisc, dmisc, mmask;
    logic [63:0] rattr, dattr, amask, tattr;
    logic [255:0] meas, ehash, signer, lhash, tmeas, tsigner;
    logic [15:0] prod, ver;
    logic busy, done, fault, zf, cm_we;
    logic [3:0] err;
    logic [255:0] cm_signer, cm_meas;
    logic [15:0] cm_prod, cm_ver;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    lp_launch_chk i_lp_launch_chk (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .dsc_addr_i(dsc_addr), .rec_addr_i(rec_addr), .tok_addr_i(tok_addr),
        .rec_init_i(rec_init), .rec_lock_i(rec_lock),
        .dsc_hdr1_i(hdr1), .dsc_vendor_i(vendor), .dsc_hdr2_i(hdr2),
        .dsc_exp_i(expo), .dsc_rsvd_i(drsvd), .sig_event_i(evt), .sig_ok_i(sig_ok),
        .dsc_family_i(family), .rec_attr_i(rattr), .dsc_attr_i(dattr), .dsc_amask_i(amask),
        .rec_misc_i(rmisc), .dsc_misc_i(dmisc), .dsc_mmask_i(mmask),
        .meas_final_i(meas), .dsc_ehash_i(ehash), .signer_dig_i(signer),
        .launcher_hash_i(lhash), .tok_valid_i(tok_valid), .tok_dbg_i(tok_dbg),
        .tok_rsvd_i(trsvd), .tok_svn_i(tok_svn), .cur_svn_i(cur_svn),
        .tok_mac_ok_i(mac_ok), .tok_meas_i(tmeas), .tok_signer_i(tsigner),
        .tok_attr_i(tattr), .dsc_prod_i(prod), .dsc_ver_i(ver),
        .busy_o(busy), .done_o(done), .fault_o(fault), .zf_o(zf), .err_o(err),
        .cm_we_o(cm_we), .cm_signer_o(cm_signer), .cm_meas_o(cm_meas),
        .cm_prod_o(cm_prod), .cm_ver_o(cm_ver)
    );

    function automatic logic [255:0] r256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference policy: expected fault, code, latency in clocks after the request edge
    function automatic void model(output bit g, output int e, output int lat);
        g = 0; e = 0; lat = 0;
        if (dsc_addr[11:0] != 0 || rec_addr[11:0] != 0 || tok_addr[8:0] != 0 || rec_init || rec_lock) begin
            g = 1; return;
        end
        if (hdr1 != H1 || hdr2 != H2 || !(vendor == 0 || vendor == 32'h8086) || expo != 3 || drsvd != 0) begin
            e = 1; lat = 1; return;
        end
        if (evt) begin e = 7; lat = 2; return; end
        if (!sig_ok) begin e = 4; lat = 1 + W; return; end
        if (family != 0 && !rattr[7]) begin e = 1; lat = 2 + W; return; end
        if (ehash != meas) begin e = 3; lat = 3 + W; return; end
        if ((rattr & 64'h20) != 0 && signer != lhash) begin e = 2; lat = 4 + W; return; end
        if ((rattr & amask) != (dattr & amask)) begin e = 2; lat = 5 + W; return; end
        if ((rmisc & mmask) != (dmisc & mmask)) begin e = 2; lat = 6 + W; return; end
        lat = 7 + W;
        if (!tok_valid) begin e = (signer == lhash) ? 0 : 5; return; end
        if (tok_dbg && !rattr[1]) begin e = 5; return; end
        lat = 8 + W;  if (trsvd != 0) begin e = 5; return; end
        lat = 9 + W;  if (tok_svn > cur_svn) begin e = 6; return; end
        lat = 10 + W; if (!mac_ok) begin e = 5; return; end
        lat = 11 + W; if (tmeas != meas || tsigner != signer) begin e = 3; return; end
        lat = 12 + W; if (tattr != rattr) e = 8;
    endfunction

    task automatic gen_good();
        dsc_addr = {$urandom, 16'h0} & ~48'hFFF;
        rec_addr = {$urandom, 16'h0} & ~48'hFFF;
        tok_addr = {$urandom, 16'h0} & ~48'h1FF;
        rec_init = 0; rec_lock = 0;
        hdr1 = H1; hdr2 = H2; vendor = ($urandom % 2) ? 32'h8086 : 32'h0; expo = 3; drsvd = 0;
        evt = 0; sig_ok = 1;
        signer = r256(); meas = r256(); ehash = meas;
        tok_valid = $urandom % 2;
        lhash = (!tok_valid || ($urandom % 2)) ? signer : r256();
        rattr = {$urandom, $urandom};
        if (lhash != signer) rattr[5] = 1'b0;
        family = rattr[7] ? {$urandom, $urandom, $urandom, $urandom} : 128'h0;
        amask = {$urandom, $urandom};
        dattr = (rattr & amask) | ({$urandom, $urandom} & ~amask);
        rmisc = $urandom; mmask = $urandom; dmisc = (rmisc & mmask) | ($urandom & ~mmask);
        tok_dbg = rattr[1] ? 1'($urandom % 2) : 1'b0;
        trsvd = 0;
        cur_svn = {1'b0, $urandom, $urandom, $urandom, 31'($urandom)};
        tok_svn = cur_svn & {$urandom, $urandom, $urandom, $urandom};
        mac_ok = 1; tmeas = meas; tsigner = signer; tattr = rattr;
        prod = 16'($urandom); ver = 16'($urandom);
    endtask

    task automatic corrupt(input int k);
        case (k)
            0: dsc_addr[3] = 1'b1;
            1: rec_addr[11] = 1'b1;
            2: tok_addr[8] = 1'b1;
            3: rec_init = 1;
            4: rec_lock = 1;
            5: hdr1[40] = ~hdr1[40];
            6: vendor = 32'h00001234;
            7: expo = 32'd65537;
            8: drsvd[9] = 1'b1;
            9: evt = 1;
            10: sig_ok = 0;
            11: begin family = 128'h1; rattr[7] = 1'b0; end
            12: ehash[0] = ~ehash[0];
            13: begin rattr[5] = 1'b1; lhash = ~signer; end
            14: begin amask[3] = 1'b1; dattr[3] = ~rattr[3]; end
            15: begin mmask[2] = 1'b1; dmisc[2] = ~rmisc[2]; end
            16: begin tok_valid = 0; lhash = ~signer; end
            17: begin tok_valid = 1; tok_dbg = 1; rattr[1] = 1'b0; end
            18: begin tok_valid = 1; trsvd = 32'h100; end
            19: begin tok_valid = 1; tok_svn = cur_svn + 1; end
            20: begin tok_valid = 1; mac_ok = 0; end
            21: begin tok_valid = 1; tsigner[7] = ~tsigner[7]; end
            22: begin tok_valid = 1; tmeas[100] = ~tmeas[100]; end
            23: begin tok_valid = 1; tattr[12] = ~tattr[12]; end
            default: ;
        endcase
    endtask

    task automatic run_vec(input string tag);
        bit g; int e, lat, seen;
        logic [3:0] held;
        model(g, e, lat);
        @(negedge clk); start = 1;
        @(posedge clk); #1; start = 0;
        seen = 0;
        while (!done && seen < 100) begin @(posedge clk); #1; seen++; end
        // R12 latency tells which stage ended the run (first failure wins)
        chk(seen == lat, tag, "latency", 256'(seen), 256'(lat));
        chk(fault == g, g ? "R1" : tag, "fault", 256'(fault), 256'(g));
        chk(err == 4'(e), tag, "err", 256'(err), 256'(e));
        chk(zf == (e != 0), "R11", "zf", 256'(zf), 256'(e != 0));
        chk(cm_we == (!g && e == 0), "R11", "commit", 256'(cm_we), 256'(!g && e == 0));
        if (!g && e == 0)
            chk(cm_signer == signer && cm_meas == meas && cm_prod == prod && cm_ver == ver,
                "R11", "commit data", cm_signer ^ signer ^ 256'(cm_prod ^ prod), 256'(0));
        held = err;
        @(posedge clk); #1;
        chk(!done && !busy, "R12", "done single", 256'({done, busy}), 256'(0));
        @(posedge clk); #1;
        chk(err == held, "R12", "hold", 256'(err), 256'(held));
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        gen_good();
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !fault && !zf && err == 0 && !cm_we, "R12", "reset",
            256'({busy, done, fault, zf, err, cm_we}), 256'(0));
        @(negedge clk); rst_n = 1;

        // Directed: every stage alone (R1..R10), plus both success paths (R9, R11)
        for (int k = 0; k < 24; k++) begin
            gen_good(); corrupt(k);
            run_vec(k < 5 ? "R1" : k < 9 ? "R2" : k == 9 ? "R3" : k == 10 ? "R4" :
                    k == 11 ? "R5" : k == 12 ? "R6" : k == 13 ? "R7" : k < 16 ? "R8" :
                    k == 16 ? "R9" : "R10");
        end
        gen_good(); tok_valid = 0; lhash = signer; run_vec("R9");
        gen_good(); tok_valid = 1; run_vec("R10");
        // Ordering corners: event beats bad signature; token SVN beats MAC
        gen_good(); corrupt(9); corrupt(10); run_vec("R3");
        gen_good(); corrupt(20); corrupt(19); run_vec("R10");

        // Constrained random: zero, one or two injected faults
        for (int i = 0; i < 400; i++) begin
            gen_good();
            if ($urandom % 3 != 0) corrupt($urandom % 24);
            if ($urandom % 4 == 0) corrupt($urandom % 24);
            run_vec("R13");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule